// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the access address for a four-beat burst on a synchronous memory port. A load strobe captures a complete external address, which becomes the first beat. After that, each clock edge that samples the active-low advance input low moves the two low-order address bits to the next beat. The upper bits never change during a burst. A high advance holds the current address, which gives the memory side a wait state without ending the burst.

A static order input picks one of two wrap orders. In linear order the low pair counts up modulo four from the start value. In interleaved order each beat is the start value XORed with the beat number. Both orders return to the start value after the fourth beat. A new load always takes precedence: it abandons any burst in progress and restarts the beat count.

The access controller that owns chip enables and write decode drives the load and advance inputs. It holds the order input constant while the port is in use.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `curAddr` to all zeros and sets the beat count to zero.
- R2: When `loadReq` is high at a rising edge, `curAddr` equals the `extAddr` sampled at that edge from that edge onward, and that address is beat 0.
- R3: When `loadReq` is high and `advN` is low at the same edge, the load wins: `curAddr` becomes `extAddr` and the next advance yields beat 1 of the new burst.
- R4: When `loadReq` is low and `advN` is high at a rising edge, `curAddr` keeps its value (wait state).
- R5: With `modeSel` = 0 (linear), beat k of a burst has low bits (start + k) mod 4, so a start of 01 gives 01, 10, 11, 00.
- R6: With `modeSel` = 1 (interleaved), beat k of a burst has low bits start XOR k, so a start of 10 gives 10, 11, 00, 01.
- R7: An advance from beat 3 returns the low bits to the start value (beat 0) in either order.
- R8: Bits `curAddr[ADDR_W-1:2]` do not change on an advance or a hold. They always equal the upper bits of the last loaded address.
- R9: A load in the middle of a burst (beat 1, 2 or 3) drops that burst, and the following advances run the order from the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| loadReq | input | 1 | Load a new external address, active high |
| extAddr | input | ADDR_W | External start address |
| advN | input | 1 | Burst advance, active low; high inserts a wait state |
| modeSel | input | 1 | Wrap order: 0 linear, 1 interleaved; static during operation |
| curAddr | output | ADDR_W | Current access address |

## Verification
The two functions that can fall in one cycle are a fresh load and a burst advance. The bench provokes this with directed edges where `loadReq` is high and `advN` is low together, and with random stimulus that lets loads land at every beat, including mid-burst and on the wrap beat. Each such cycle is judged by checking that the address equals the newly presented one rather than a stepped old one. The advance on the following edge is then checked to produce beat 1 of the new order.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BURST_LEN = 4;
  localparam int LOW_W     = $clog2(BURST_LEN);

  typedef struct packed {
    logic loadNew;
    logic stepBeat;
  } seqStrobe_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       loadReq,
  input  logic       advN,
  output seqStrobe_t strobes
);
  // load has priority; an advance in the same cycle is dropped
  always_comb begin
    strobes.loadNew  = loadReq;
    strobes.stepBeat = !loadReq && !advN;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobes,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int UP_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [LOW_W-1:0]  beatCnt;
  logic [LOW_W-1:0]  linearLow;
  logic [LOW_W-1:0]  interLow;
  logic [LOW_W-1:0]  lowSel;
  burstOrder_t       order;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strobes.loadNew) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (strobes.stepBeat) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  assign linearLow = baseAddr[LOW_W-1:0] + beatCnt;

  for (genvar b = 0; b < LOW_W; b++) begin : g_xorBit
    assign interLow[b] = baseAddr[b] ^ beatCnt[b];
  end

  assign order = burstOrder_t'(modeSel);

  always_comb begin
    case (order)
      ORDER_INTERLEAVE: lowSel = interLow;
      default:          lowSel = linearLow;
    endcase
  end

  assign curAddr = {baseAddr[ADDR_W-1 -: UP_W], lowSel};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              advN,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] curAddr
);
  seqStrobe_t strobes;

  burst_seq_ctrl u_ctrl (
    .loadReq (loadReq),
    .advN    (advN),
    .strobes (strobes)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .extAddr (extAddr),
    .modeSel (modeSel),
    .curAddr (curAddr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              loadReq,
  input logic [ADDR_W-1:0] extAddr,
  input logic              advN,
  input logic              modeSel,
  input logic [ADDR_W-1:0] curAddr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> curAddr == '0);

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    loadReq |=> curAddr == $past(extAddr));

  p_load_beats_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (loadReq && !advN) |=> curAddr == $past(extAddr));

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!loadReq && advN) |=> $stable(curAddr));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!loadReq && !advN && !modeSel) |=> curAddr[1:0] == $past(curAddr[1:0]) + 2'd1);

  p_inter_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (!loadReq && !advN && modeSel) |=> curAddr[0] != $past(curAddr[0]));

  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    !loadReq |=> curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .loadReq (loadReq),
  .extAddr (extAddr),
  .advN    (advN),
  .modeSel (modeSel),
  .curAddr (curAddr)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              loadReq = 1'b0;
  logic [ADDR_W-1:0] extAddr = '0;
  logic              advN = 1'b1;
  logic              modeSel = 1'b0;
  logic [ADDR_W-1:0] curAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [ADDR_W-1:0] refBase = '0;
  logic [1:0]        refBeat = '0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .loadReq(loadReq), .extAddr(extAddr),
    .advN(advN), .modeSel(modeSel), .curAddr(curAddr)
  );

  function automatic logic [1:0] beatLow(input logic [1:0] start, input logic [1:0] k,
                                         input logic mode);
    return mode ? (start ^ k) : (start + k);
  endfunction

  function automatic logic [ADDR_W-1:0] expAddr();
    return {refBase[ADDR_W-1:2], beatLow(refBase[1:0], refBeat, modeSel)};
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] got,
                       input logic [ADDR_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: curAddr=%h expected=%h", req, got, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, sample 1 ns later
  task automatic cycle(input logic doRst, input logic ld, input logic [ADDR_W-1:0] addr,
                       input logic adv_n);
    string req;
    logic [1:0] oldBeat;
    logic [ADDR_W-1:0] oldAddr;
    @(negedge clk);
    rst = doRst; loadReq = ld; extAddr = addr; advN = adv_n;
    oldBeat = refBeat;
    oldAddr = curAddr;
    @(posedge clk);
    if (doRst) begin
      refBase = '0; refBeat = '0; req = "R1";
    end else if (ld) begin
      refBase = addr; refBeat = '0;
      if (!adv_n) req = "R3";
      else if (oldBeat != 2'd0) req = "R9";
      else req = "R2";
    end else if (!adv_n) begin
      refBeat = refBeat + 2'd1;
      if (refBeat == 2'd0) req = "R7";
      else req = modeSel ? "R6" : "R5";
    end else begin
      req = "R4";
    end
    #1;
    check(req, curAddr, expAddr());
    if (!doRst && !ld) begin
      checks++;
      if (curAddr[ADDR_W-1:2] !== oldAddr[ADDR_W-1:2]) begin
        errors++;
        $display("FAIL R8: upper=%h expected=%h", curAddr[ADDR_W-1:2], oldAddr[ADDR_W-1:2]);
      end
    end
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++) begin
      logic ld;
      ld = ($urandom % 6) == 0;
      cycle(1'b0, ld, ADDR_W'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4711);
    // R1: reset state
    cycle(1'b1, 1'b0, '0, 1'b1);
    cycle(1'b1, 1'b0, '0, 1'b0);

    // R5 linear, start 01: 01,10,11,00 then wrap (R7)
    modeSel = 1'b0;
    cycle(1'b0, 1'b1, 16'hA5C1, 1'b1);
    for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, '0, 1'b0);
    // R4 wait states mid-burst
    cycle(1'b0, 1'b0, '0, 1'b0);
    cycle(1'b0, 1'b0, 16'hFFFF, 1'b1);
    cycle(1'b0, 1'b0, '0, 1'b1);
    // R9 abort mid-burst, R3 load with advance in same cycle
    cycle(1'b0, 1'b1, 16'h1233, 1'b1);
    cycle(1'b0, 1'b0, '0, 1'b0);
    cycle(1'b0, 1'b1, 16'h7772, 1'b0);
    cycle(1'b0, 1'b0, '0, 1'b0);
    randomRun(400);

    // R6 interleaved, start 10: 10,11,00,01 then wrap
    cycle(1'b1, 1'b0, '0, 1'b1);
    modeSel = 1'b1;
    cycle(1'b0, 1'b1, 16'h3C02, 1'b1);
    for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, '0, 1'b0);
    cycle(1'b0, 1'b1, 16'h0003, 1'b0);
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, '0, 1'b0);
    cycle(1'b0, 1'b1, 16'hBEE1, 1'b1);
    randomRun(400);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule